// File: doc/BRIEF.md
# PCI Target Termination Decoder

This block watches the target-side handshake of a PCI-style bus and reports how each data phase ends. The five active-low control pins (frame, initiator ready, target ready, stop, device select) are sampled on every rising clock edge. When a data phase completes, exactly one registered event pulse appears in the following cycle. The event is a plain transfer, a disconnect that moved data, a disconnect that moved none, a retry, or a target abort. To tell a retry apart from a data-less disconnect, the block remembers whether any data has moved since the initiator started the transaction. It also counts the transferred data phases of the current transaction and flags a target that withdraws its ready before the phase completes.

The block also drives the target's own ready and stop pins, which are sustained-tristate signals. While the local target owns the transaction, the block drives each pin from a request input. When ownership ends, it drives both pins deasserted (high) for exactly one clock. It then releases the shared output enable so that the external pull-ups hold the lines.

Top module: `pci_term_decoder`

## Requirements
- R1: During and directly after a synchronous reset, all five event outputs, `proto_err`, `phase_cnt` and `ctl_oe` are 0, and `trdy_drv_n` and `stop_drv_n` are 1.
- R2: A data phase completes only at an edge where irdy is asserted (low) together with trdy or stop. Any other sample produces no event. The event appears in the cycle after that edge, and at most one event output is high in a cycle.
- R3: irdy, trdy and devsel asserted with stop deasserted give a one-cycle `ev_xfer` pulse.
- R4: irdy, stop, trdy and devsel all asserted give `ev_disc_data`, whether or not earlier data has moved.
- R5: irdy, stop and devsel asserted with trdy deasserted give `ev_disc_nodata` when at least one data phase has already transferred since frame was asserted out of idle.
- R6: The same pin pattern as R5, seen while no data has yet transferred since the bus left idle, gives `ev_retry` instead.
- R7: irdy and stop asserted with devsel deasserted give `ev_abort`, regardless of trdy.
- R8: `phase_cnt` increments by one for every sample with irdy, trdy and devsel all asserted. It saturates at its all-ones value, and it returns to 0 after any sample in which frame and irdy are both deasserted (bus idle). The count is visible in the cycle after the sample.
- R9: If trdy was asserted while irdy was deasserted at one edge, and trdy is deasserted at the next edge, `proto_err` pulses for one cycle after that next edge.
- R10: After an edge at which `tgt_own` is 1, `ctl_oe` is 1, `trdy_drv_n` equals the inverse of `tgt_trdy_req`, and `stop_drv_n` equals the inverse of `tgt_stop_req`, all as sampled at that edge.
- R11: After the first edge with `tgt_own` at 0 following ownership, `ctl_oe` stays 1 with both driven pins at 1 for one cycle. At the next edge, if `tgt_own` is still 0, `ctl_oe` goes to 0 and both pins read 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_n | input | 1 | Sampled frame pin, active low |
| irdy_n | input | 1 | Sampled initiator-ready pin, active low |
| trdy_n | input | 1 | Sampled target-ready pin, active low |
| stop_n | input | 1 | Sampled stop pin, active low |
| devsel_n | input | 1 | Sampled device-select pin, active low |
| tgt_own | input | 1 | Local target owns the current transaction |
| tgt_trdy_req | input | 1 | Local target wants its ready pin asserted |
| tgt_stop_req | input | 1 | Local target wants its stop pin asserted |
| trdy_drv_n | output | 1 | Driven value for the ready pin |
| stop_drv_n | output | 1 | Driven value for the stop pin |
| ctl_oe | output | 1 | Output enable shared by both driven pins |
| ev_xfer | output | 1 | Pulse: plain data transfer |
| ev_disc_data | output | 1 | Pulse: disconnect with data |
| ev_disc_nodata | output | 1 | Pulse: disconnect without data |
| ev_retry | output | 1 | Pulse: retry |
| ev_abort | output | 1 | Pulse: target abort |
| proto_err | output | 1 | Pulse: ready withdrawn before phase completion |
| phase_cnt | output | CNT_W | Data phases transferred in this transaction |

## Verification
The bound checker watches several properties on every cycle. It checks that the event outputs are mutually exclusive, and that an abort only follows a sample with devsel deasserted. It checks that a retry never appears with a nonzero count, that the count is zero after every idle sample, and that the output enable only falls after a cycle that parked both pins high. It also checks that a protocol error is always preceded by the early-withdrawal pattern. Only the bench's scenarios can show the rest, because those properties depend on the history of a whole transaction. These are the exact retry versus disconnect decision after earlier transfers, counter saturation across hundreds of phases, and the full own, park and release sequence of the pin driver.

// File: rtl/pci_term_pkg.sv
package pci_term_pkg;

    typedef enum logic [2:0] {
        TERM_NONE,
        TERM_XFER,
        TERM_DISC_DATA,
        TERM_DISC_NODATA,
        TERM_RETRY,
        TERM_ABORT
    } term_e;

    typedef enum logic [1:0] {
        DRV_IDLE,
        DRV_ACTIVE,
        DRV_PARK
    } drv_e;

    // Bus pins converted to active-high "asserted" form.
    typedef struct packed {
        logic frame;
        logic irdy;
        logic trdy;
        logic stop;
        logic devsel;
    } bus_s;

    function automatic bus_s to_asserted(input logic f_n, input logic i_n,
                                         input logic t_n, input logic s_n,
                                         input logic d_n);
        bus_s b;
        b.frame  = ~f_n;
        b.irdy   = ~i_n;
        b.trdy   = ~t_n;
        b.stop   = ~s_n;
        b.devsel = ~d_n;
        return b;
    endfunction

    function automatic logic bus_idle(input bus_s b);
        return ~b.frame & ~b.irdy;
    endfunction

    function automatic logic data_moved(input bus_s b);
        return b.irdy & b.trdy & b.devsel;
    endfunction

    // Decide how the current sample ends a data phase.
    function automatic term_e classify(input bus_s b, input logic no_data_yet);
        term_e t;
        t = TERM_NONE;
        if (b.irdy) begin
            if (b.stop && !b.devsel)
                t = TERM_ABORT;
            else if (b.stop && b.trdy)
                t = TERM_DISC_DATA;
            else if (b.stop)
                t = no_data_yet ? TERM_RETRY : TERM_DISC_NODATA;
            else if (b.trdy && b.devsel)
                t = TERM_XFER;
        end
        return t;
    endfunction

endpackage

// File: rtl/pti_phase_track.sv
module pti_phase_track
    import pci_term_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_s             bus,
    output logic             first_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             first_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q <= 1'b1;
            cnt_q   <= '0;
        end else if (bus_idle(bus)) begin
            first_q <= 1'b1;
            cnt_q   <= '0;
        end else if (data_moved(bus)) begin
            first_q <= 1'b0;
            if (cnt_q != CNT_MAX)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign first_o = first_q;
    assign cnt_o   = cnt_q;

endmodule

// File: rtl/pti_term_classify.sv
module pti_term_classify
    import pci_term_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  bus_s  bus,
    input  logic  first,
    output term_e evt_o,
    output logic  err_o
);

    term_e evt_q;
    logic  pend_q;
    logic  err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q  <= TERM_NONE;
            pend_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            evt_q  <= classify(bus, first);
            // Ready shown while the initiator has not yet completed the phase.
            pend_q <= bus.trdy & ~bus.irdy;
            err_q  <= pend_q & ~bus.trdy;
        end
    end

    assign evt_o = evt_q;
    assign err_o = err_q;

endmodule

// File: rtl/pti_pin_park.sv
module pti_pin_park
    import pci_term_pkg::*;
#(
    parameter int NPINS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             own,
    input  logic [NPINS-1:0] req,
    output logic [NPINS-1:0] pin_n,
    output logic             oe
);

    drv_e st_q, st_d;

    always_comb begin
        st_d = DRV_IDLE;
        if (own)
            st_d = DRV_ACTIVE;
        else if (st_q == DRV_ACTIVE)
            st_d = DRV_PARK;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= DRV_IDLE;
        else     st_q <= st_d;
    end

    assign oe = (st_q != DRV_IDLE);

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        logic pin_q;
        always_ff @(posedge clk) begin
            if (rst)
                pin_q <= 1'b1;
            else
                pin_q <= (st_d == DRV_ACTIVE) ? ~req[g] : 1'b1;
        end
        assign pin_n[g] = pin_q;
    end

endmodule

// File: rtl/pci_term_decoder.sv
module pci_term_decoder
    import pci_term_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_n,
    input  logic             irdy_n,
    input  logic             trdy_n,
    input  logic             stop_n,
    input  logic             devsel_n,
    input  logic             tgt_own,
    input  logic             tgt_trdy_req,
    input  logic             tgt_stop_req,
    output logic             trdy_drv_n,
    output logic             stop_drv_n,
    output logic             ctl_oe,
    output logic             ev_xfer,
    output logic             ev_disc_data,
    output logic             ev_disc_nodata,
    output logic             ev_retry,
    output logic             ev_abort,
    output logic             proto_err,
    output logic [CNT_W-1:0] phase_cnt
);

    localparam int NPINS = 2;

    bus_s             bus;
    logic             first;
    term_e            evt;
    logic [NPINS-1:0] drv_n;

    assign bus = to_asserted(frame_n, irdy_n, trdy_n, stop_n, devsel_n);

    pti_phase_track #(.CNT_W(CNT_W)) u_track (
        .clk     (clk),
        .rst     (rst),
        .bus     (bus),
        .first_o (first),
        .cnt_o   (phase_cnt)
    );

    pti_term_classify u_class (
        .clk   (clk),
        .rst   (rst),
        .bus   (bus),
        .first (first),
        .evt_o (evt),
        .err_o (proto_err)
    );

    pti_pin_park #(.NPINS(NPINS)) u_park (
        .clk   (clk),
        .rst   (rst),
        .own   (tgt_own),
        .req   ({tgt_stop_req, tgt_trdy_req}),
        .pin_n (drv_n),
        .oe    (ctl_oe)
    );

    assign trdy_drv_n     = drv_n[0];
    assign stop_drv_n     = drv_n[1];
    assign ev_xfer        = (evt == TERM_XFER);
    assign ev_disc_data   = (evt == TERM_DISC_DATA);
    assign ev_disc_nodata = (evt == TERM_DISC_NODATA);
    assign ev_retry       = (evt == TERM_RETRY);
    assign ev_abort       = (evt == TERM_ABORT);

endmodule

// File: rtl/pci_term_decoder_chk.sv
module pci_term_decoder_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             frame_n,
    input logic             irdy_n,
    input logic             trdy_n,
    input logic             stop_n,
    input logic             devsel_n,
    input logic             tgt_own,
    input logic             trdy_drv_n,
    input logic             stop_drv_n,
    input logic             ctl_oe,
    input logic             ev_xfer,
    input logic             ev_disc_data,
    input logic             ev_disc_nodata,
    input logic             ev_retry,
    input logic             ev_abort,
    input logic             proto_err,
    input logic [CNT_W-1:0] phase_cnt
);

    p_evt_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev_xfer, ev_disc_data, ev_disc_nodata, ev_retry, ev_abort}));

    p_abort_nodevsel_r7: assert property (@(posedge clk) disable iff (rst)
        ev_abort |-> ($past(devsel_n) && !$past(stop_n) && !$past(irdy_n)));

    p_retry_nodata_r6: assert property (@(posedge clk) disable iff (rst)
        ev_retry |-> (phase_cnt == '0));

    p_cnt_live_r8: assert property (@(posedge clk) disable iff (rst)
        (ev_xfer || ev_disc_data) |-> (phase_cnt != '0));

    p_cnt_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (frame_n && irdy_n) |=> (phase_cnt == '0));

    p_err_cause_r9: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> ($past(trdy_n) && !$past(trdy_n, 2) && $past(irdy_n, 2)));

    p_own_drive_r10: assert property (@(posedge clk) disable iff (rst)
        tgt_own |=> ctl_oe);

    p_park_high_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl_oe) |-> ($past(trdy_drv_n) && $past(stop_drv_n)));

endmodule

bind pci_term_decoder pci_term_decoder_chk #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .frame_n        (frame_n),
    .irdy_n         (irdy_n),
    .trdy_n         (trdy_n),
    .stop_n         (stop_n),
    .devsel_n       (devsel_n),
    .tgt_own        (tgt_own),
    .trdy_drv_n     (trdy_drv_n),
    .stop_drv_n     (stop_drv_n),
    .ctl_oe         (ctl_oe),
    .ev_xfer        (ev_xfer),
    .ev_disc_data   (ev_disc_data),
    .ev_disc_nodata (ev_disc_nodata),
    .ev_retry       (ev_retry),
    .ev_abort       (ev_abort),
    .proto_err      (proto_err),
    .phase_cnt      (phase_cnt)
);

// File: tb/pci_term_decoder_bench.sv
`timescale 1ns/1ps
module pci_term_decoder_bench;

    localparam int CNT_W = 8;
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1, stop_n = 1'b1, devsel_n = 1'b1;
    logic tgt_own = 1'b0, tgt_trdy_req = 1'b0, tgt_stop_req = 1'b0;
    logic trdy_drv_n, stop_drv_n, ctl_oe;
    logic ev_xfer, ev_disc_data, ev_disc_nodata, ev_retry, ev_abort, proto_err;
    logic [CNT_W-1:0] phase_cnt;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Reference state
    bit m_first = 1'b1;
    int m_cnt = 0;
    bit m_pend = 1'b0;
    int m_drv = 0; // 0 idle, 1 active, 2 park

    always #2.5 clk = ~clk;

    pci_term_decoder #(.CNT_W(CNT_W)) u_pci_term_decoder (
        .clk(clk), .rst(rst),
        .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
        .stop_n(stop_n), .devsel_n(devsel_n),
        .tgt_own(tgt_own), .tgt_trdy_req(tgt_trdy_req), .tgt_stop_req(tgt_stop_req),
        .trdy_drv_n(trdy_drv_n), .stop_drv_n(stop_drv_n), .ctl_oe(ctl_oe),
        .ev_xfer(ev_xfer), .ev_disc_data(ev_disc_data), .ev_disc_nodata(ev_disc_nodata),
        .ev_retry(ev_retry), .ev_abort(ev_abort), .proto_err(proto_err),
        .phase_cnt(phase_cnt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected one-hot {abort,retry,nodata,data,xfer} from asserted-form pins.
    function automatic logic [4:0] exp_event(bit f, bit i, bit t, bit s, bit d, bit first);
        if (!i)            return 5'b00000;
        if (s && !d)       return 5'b10000; // R7
        if (s && t)        return 5'b00010; // R4
        if (s)             return first ? 5'b01000 : 5'b00100; // R6 / R5
        if (t && d)        return 5'b00001; // R3
        return 5'b00000;
    endfunction

    function automatic string event_tag(logic [4:0] e);
        case (e)
            5'b00001: return "R3";
            5'b00010: return "R4";
            5'b00100: return "R5";
            5'b01000: return "R6";
            5'b10000: return "R7";
            default:  return "R2";
        endcase
    endfunction

    // One bus cycle; arguments are asserted (1 = pin low).
    task automatic step(input bit f, input bit i, input bit t, input bit s, input bit d,
                        input bit own, input bit treq, input bit sreq);
        logic [4:0] e_evt;
        bit e_err, e_oe, e_tp, e_sp;
        int e_cnt;
        @(negedge clk);
        frame_n = !f; irdy_n = !i; trdy_n = !t; stop_n = !s; devsel_n = !d;
        tgt_own = own; tgt_trdy_req = treq; tgt_stop_req = sreq;
        e_evt = exp_event(f, i, t, s, d, m_first);
        e_err = m_pend && !t;
        m_pend = t && !i;
        e_cnt = m_cnt;
        if (!f && !i) begin
            m_first = 1'b1; e_cnt = 0;
        end else if (i && t && d) begin
            m_first = 1'b0;
            if (e_cnt != CNT_MAX) e_cnt = e_cnt + 1;
        end
        m_cnt = e_cnt;
        if (own) m_drv = 1;
        else if (m_drv == 1) m_drv = 2;
        else m_drv = 0;
        e_oe = (m_drv != 0);
        e_tp = (m_drv == 1) ? !treq : 1'b1;
        e_sp = (m_drv == 1) ? !sreq : 1'b1;
        @(posedge clk);
        #1;
        chk(event_tag(e_evt),
            {27'd0, ev_abort, ev_retry, ev_disc_nodata, ev_disc_data, ev_xfer}, {27'd0, e_evt});
        chk("R8", 32'(phase_cnt), 32'(e_cnt));
        chk("R9", {31'd0, proto_err}, {31'd0, e_err});
        chk((m_drv == 1) ? "R10" : "R11", {29'd0, ctl_oe, trdy_drv_n, stop_drv_n},
            {29'd0, e_oe, e_tp, e_sp});
    endtask

    task automatic idle_cycle();
        step(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        void'($urandom(32'h2b7c_0115));
        repeat (3) @(posedge clk);
        #1;
        // R1: state while reset is held
        chk("R1", {22'd0, ev_xfer, ev_disc_data, ev_disc_nodata, ev_retry, ev_abort,
                   proto_err, ctl_oe, trdy_drv_n, stop_drv_n, 1'b0},
                  {22'd0, 5'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0});
        chk("R1", 32'(phase_cnt), 32'd0);
        @(negedge clk);
        rst = 1'b0;
        idle_cycle();

        // R6: stop without data on the first phase is a retry
        step(1, 0, 0, 0, 0, 0, 0, 0);
        step(1, 1, 0, 1, 1, 0, 0, 0);
        idle_cycle();
        // R3 then R5: transfers followed by data-less disconnect
        step(1, 1, 1, 0, 1, 0, 0, 0);
        step(1, 1, 1, 0, 1, 0, 0, 0);
        step(1, 1, 1, 0, 1, 0, 0, 0);
        step(0, 1, 0, 1, 1, 0, 0, 0);
        idle_cycle();
        // R4: disconnect with data on the first phase
        step(0, 1, 1, 1, 1, 0, 0, 0);
        idle_cycle();
        // R7: abort with and without trdy
        step(1, 1, 0, 1, 0, 0, 0, 0);
        step(0, 1, 1, 1, 0, 0, 0, 0);
        idle_cycle();
        // R2: stop asserted with irdy deasserted completes nothing
        step(1, 0, 1, 1, 1, 0, 0, 0);
        step(1, 0, 0, 0, 1, 0, 0, 0);
        idle_cycle();
        // R9: ready shown early then withdrawn
        step(1, 0, 1, 0, 1, 0, 0, 0);
        step(1, 0, 0, 0, 1, 0, 0, 0);
        idle_cycle();
        // R8: saturation of the phase count, then clear on idle
        for (int k = 0; k < CNT_MAX + 6; k++) step(1, 1, 1, 0, 1, 0, 0, 0);
        chk("R8", 32'(phase_cnt), 32'(CNT_MAX));
        idle_cycle();
        chk("R8", 32'(phase_cnt), 32'd0);
        // R10 / R11: own, drive, park one cycle, release
        step(0, 0, 0, 0, 0, 1, 1, 0);
        step(0, 0, 0, 0, 0, 1, 0, 1);
        step(0, 0, 0, 0, 0, 1, 1, 1);
        step(0, 0, 0, 0, 0, 0, 1, 1);
        chk("R11", {30'd0, ctl_oe, trdy_drv_n & stop_drv_n}, {30'd0, 2'b11});
        step(0, 0, 0, 0, 0, 0, 1, 1);
        chk("R11", {31'd0, ctl_oe}, 32'd0);
        // R11: regaining ownership during the park cycle
        step(0, 0, 0, 0, 0, 1, 1, 1);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 1, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);

        // Constrained random traffic
        begin
            bit own_r = 1'b0;
            for (int n = 0; n < 4000; n++) begin
                bit f, i, t, s, d, tr, sr;
                f = ($urandom_range(0, 3) != 0);
                i = ($urandom_range(0, 3) != 0);
                t = ($urandom_range(0, 2) != 0);
                s = ($urandom_range(0, 5) == 0);
                d = ($urandom_range(0, 7) != 0);
                if ($urandom_range(0, 9) == 0) begin f = 0; i = 0; end
                if ($urandom_range(0, 5) == 0) own_r = !own_r;
                tr = $urandom_range(0, 1) != 0;
                sr = $urandom_range(0, 1) != 0;
                step(f, i, t, s, d, own_r, tr, sr);
            end
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule